// File: doc/BRIEF.md
# Byte-Wide Program Memory Programming Controller

This block runs the programming side of a 1024-byte program store. The store is kept inside the block as a register array. A host sends it four kinds of command: write one byte, read one byte back for checking, erase the whole array, and set a protection bit. The host does not send an address. The block keeps its own byte pointer. A rising edge on `prog_rst` sends the pointer to zero, and each rising edge on `step_pulse` moves it forward by one.

Two protection bits guard the contents. The write guard refuses any further byte writes. The read guard makes every check-read return the blank value instead of the stored byte. A byte that already holds data cannot be written again. The only way to clear a byte, and the only way to clear either protection bit, is a whole-array erase. The erase keeps `busy` high for `ERASE_CYCLES` clock cycles. A refused write raises `error` for exactly one cycle.

The controller is a five-state machine:
- ST_IDLE accepts a command. It goes to ST_PROG on op 2'b00, to ST_VERIFY on op 2'b01, to ST_ERASE on op 2'b10 and to ST_LOCK on op 2'b11.
- ST_PROG, ST_VERIFY and ST_LOCK each last one cycle and then return to ST_IDLE.
- ST_ERASE counts down. When the count reaches zero it clears the array and returns to ST_IDLE.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After `rst_n` is released, `busy`, `error` and `rd_valid` are 0, both protection bits are clear, and every location reads 0xFF.
- R2: A rising edge of `prog_rst` sets the byte pointer to 0x000. Holding `prog_rst` high does not keep the pointer at zero, so later steps still advance it.
- R3: Each rising edge of `step_pulse` advances the pointer by exactly one, however long the pulse stays high. The pointer wraps from 0x3FF to 0x000.
- R4: A write command (op 2'b00, byte on `cmd_data`) stores the byte at the pointer when the target reads 0xFF and the write guard is clear. It keeps `busy` high for one cycle and leaves `error` low.
- R5: A write to a location that does not read 0xFF is refused. The array is left unchanged and `error` is high for exactly one cycle.
- R6: A protect command (op 2'b11) sets the write guard when `cmd_data[0]` is 0 and the read guard when `cmd_data[0]` is 1.
- R7: While the write guard is set, every write command is refused, with the array unchanged and a one-cycle `error`.
- R8: While the read guard is set, a check-read returns 0xFF, whatever the stored byte is.
- R9: A check-read (op 2'b01) pulses `rd_valid` for one cycle, two clock edges after the command edge. At the same time `rd_data` carries the byte at the pointer. `rd_data` holds its value between reads.
- R10: An erase command (op 2'b10) holds `busy` high for exactly `ERASE_CYCLES` cycles. After that every byte reads 0xFF and both protection bits are clear.
- R11: A command presented while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| prog_rst | input | 1 | Pointer clear; acts on its rising edge |
| step_pulse | input | 1 | Pointer advance; acts on its rising edge |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 00 write, 01 check-read, 10 erase, 11 protect |
| cmd_data | input | DATA_W | Byte to write, or guard select in bit 0 |
| busy | output | 1 | Command in progress |
| error | output | 1 | One-cycle flag for a refused write |
| rd_valid | output | 1 | One-cycle check-read strobe |
| rd_data | output | DATA_W | Check-read result |

## Verification
The following rules hold on every cycle, and the assertions check them:
- `error` and `rd_valid` are single-cycle pulses.
- A write under the write guard always ends in `error`.
- A read under the read guard returns the blank byte.
- One-cycle states return straight to ST_IDLE, so overlapping commands are dropped.
- Erase leaves both guards clear.
- The pointer clears and wraps as required.

Other behaviours show only through the bench's scenarios, which compare outputs on every cycle against an independent reference model:
- Bytes are actually stored.
- A rewrite is refused and the stored byte survives.
- The erase lasts exactly `ERASE_CYCLES` cycles.
- A full lap of 1024 steps returns the pointer to the same byte.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_VERIFY,
        ST_ERASE,
        ST_LOCK
    } fp_state_t;

    typedef enum logic [1:0] {
        OP_PROG   = 2'b00,
        OP_VERIFY = 2'b01,
        OP_ERASE  = 2'b10,
        OP_LOCK   = 2'b11
    } fp_op_t;

endpackage

// File: rtl/flash_edge_det.sv
module flash_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig_in;
    end

    assign rise = sig_in & ~prev_q;
endmodule

// File: rtl/flash_addr_ctr.sv
module flash_addr_ctr #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_evt,
    input  logic              step_evt,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n)         addr_q <= '0;
        else if (clear_evt) addr_q <= '0;
        else if (step_evt)  addr_q <= addr_q + 1'b1;
    end

    assign addr = addr_q;

    // R2
    clear_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_evt |=> (addr == '0));

    // R3
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_evt && !clear_evt && addr == TOP_ADDR) |=> (addr == '0));

    // R3
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_evt && !clear_evt) |=> $stable(addr));
endmodule

// File: rtl/flash_mem_array.sv
module flash_mem_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              erase_all,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [DATA_W-1:0] BLANK = {DATA_W{1'b1}};

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n || erase_all) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= BLANK;
        end else if (wr_en) begin
            cells[addr] <= wr_data;
        end
    end

    assign rd_data = cells[addr];

    // R5
    write_only_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (rd_data == BLANK));
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
    import flash_prog_pkg::*;
#(
    parameter int ADDR_W       = 10,
    parameter int DATA_W       = 8,
    parameter int ERASE_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_rst,
    input  logic              step_pulse,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              busy,
    output logic              error,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    localparam int CNT_W = $clog2(ERASE_CYCLES) + 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ERASE_CYCLES - 1);
    localparam logic [DATA_W-1:0] BLANK = {DATA_W{1'b1}};

    fp_state_t         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] data_q;
    logic              lock1_q, lock2_q;
    logic              err_q, rdv_q;
    logic [DATA_W-1:0] rdd_q;

    logic              clr_evt, step_evt;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] cell_rd;
    logic              prog_refuse, mem_wr, mem_erase;

    flash_edge_det u_clr_edge (
        .clk(clk), .rst_n(rst_n), .sig_in(prog_rst), .rise(clr_evt)
    );

    flash_edge_det u_step_edge (
        .clk(clk), .rst_n(rst_n), .sig_in(step_pulse), .rise(step_evt)
    );

    flash_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .clear_evt(clr_evt),
        .step_evt(step_evt), .addr(addr)
    );

    flash_mem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(mem_wr),
        .wr_data(data_q), .erase_all(mem_erase), .rd_data(cell_rd)
    );

    assign prog_refuse = lock1_q || (cell_rd != BLANK);
    assign mem_wr      = (state_q == ST_PROG) && !prog_refuse;
    assign mem_erase   = (state_q == ST_ERASE) && (cnt_q == '0);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    unique case (fp_op_t'(cmd_op))
                        OP_PROG:   state_d = ST_PROG;
                        OP_VERIFY: state_d = ST_VERIFY;
                        OP_ERASE:  state_d = ST_ERASE;
                        OP_LOCK:   state_d = ST_LOCK;
                    endcase
                end
            end
            ST_PROG:   state_d = ST_IDLE;
            ST_VERIFY: state_d = ST_IDLE;
            ST_LOCK:   state_d = ST_IDLE;
            ST_ERASE:  if (cnt_q == '0) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            data_q  <= '0;
            lock1_q <= 1'b0;
            lock2_q <= 1'b0;
            err_q   <= 1'b0;
            rdv_q   <= 1'b0;
            rdd_q   <= BLANK;
        end else begin
            err_q <= 1'b0;
            rdv_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        data_q <= cmd_data;
                        cnt_q  <= CNT_LOAD;
                    end
                end
                ST_PROG: begin
                    if (prog_refuse) err_q <= 1'b1;
                end
                ST_VERIFY: begin
                    rdv_q <= 1'b1;
                    rdd_q <= lock2_q ? BLANK : cell_rd;
                end
                ST_LOCK: begin
                    if (data_q[0]) lock2_q <= 1'b1;
                    else           lock1_q <= 1'b1;
                end
                ST_ERASE: begin
                    if (cnt_q == '0) begin
                        lock1_q <= 1'b0;
                        lock2_q <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign error    = err_q;
    assign rd_valid = rdv_q;
    assign rd_data  = rdd_q;

    // R5
    err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> !error);

    // R9
    rdv_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R7
    lock1_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG && lock1_q) |=> error);

    // R8
    lock2_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(lock2_q)) |-> (rd_data == BLANK));

    // R10
    erase_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERASE && cnt_q == '0) |=> (!busy && !lock1_q && !lock2_q));

    // R11
    short_op_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG || state_q == ST_VERIFY || state_q == ST_LOCK)
            |=> (state_q == ST_IDLE));
endmodule

// File: tb/flash_prog_ctrl_bench.sv
module flash_prog_ctrl_bench;
    localparam int ERASE_CYC = 16;
    localparam int DEPTH     = 1024;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prog_rst = 1'b0;
    logic       step_pulse = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic [7:0] cmd_data = 8'h00;
    logic       busy, error, rd_valid;
    logic [7:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    flash_prog_ctrl #(.ADDR_W(10), .DATA_W(8), .ERASE_CYCLES(ERASE_CYC)) u_flash_prog_ctrl (
        .clk(clk), .rst_n(rst_n), .prog_rst(prog_rst), .step_pulse(step_pulse),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .busy(busy), .error(error), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    logic [7:0] m_mem [DEPTH];
    int   m_phase, m_cnt, m_addr;
    bit   m_lb1, m_lb2, m_prev_rst, m_prev_step;
    logic [7:0] m_dat, m_rd;
    bit   m_err, m_rv;

    task automatic model_reset();
        for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
        m_phase = 0; m_cnt = 0; m_addr = 0;
        m_lb1 = 0; m_lb2 = 0; m_prev_rst = 0; m_prev_step = 0;
        m_dat = 8'h00; m_rd = 8'hFF; m_err = 0; m_rv = 0;
    endtask

    task automatic model_edge(input bit v, input logic [1:0] op, input logic [7:0] d,
                              input bit pr, input bit sp);
        bit ne, nr;
        ne = 0; nr = 0;
        if (m_phase == 0) begin
            if (v) begin
                m_dat = d;
                m_cnt = ERASE_CYC - 1;
                m_phase = (op == 2'b00) ? 1 : (op == 2'b01) ? 2 : (op == 2'b10) ? 3 : 4;
            end
        end else if (m_phase == 1) begin
            if (m_lb1 || m_mem[m_addr] != 8'hFF) ne = 1;
            else m_mem[m_addr] = m_dat;
            m_phase = 0;
        end else if (m_phase == 2) begin
            nr = 1;
            m_rd = m_lb2 ? 8'hFF : m_mem[m_addr];
            m_phase = 0;
        end else if (m_phase == 3) begin
            if (m_cnt == 0) begin
                for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
                m_lb1 = 0; m_lb2 = 0; m_phase = 0;
            end else m_cnt--;
        end else begin
            if (m_dat[0]) m_lb2 = 1; else m_lb1 = 1;
            m_phase = 0;
        end
        if (pr && !m_prev_rst) m_addr = 0;
        else if (sp && !m_prev_step) m_addr = (m_addr + 1) % DEPTH;
        m_prev_rst = pr; m_prev_step = sp;
        m_err = ne; m_rv = nr;
    endtask

    initial model_reset();

    always @(posedge clk) begin
        bit v, pr, sp, rn;
        logic [1:0] op;
        logic [7:0] d;
        v = cmd_valid; op = cmd_op; d = cmd_data; pr = prog_rst; sp = step_pulse; rn = rst_n;
        if (!rn) model_reset();
        else model_edge(v, op, d, pr, sp);
        #2;
        if (!done) begin
            check(busy == (m_phase != 0), "R11 busy vs model", busy, (m_phase != 0));
            check(error == m_err, "R5 error vs model", error, m_err);
            check(rd_valid == m_rv, "R9 rd_valid vs model", rd_valid, m_rv);
            check(rd_data == m_rd, "R8 rd_data vs model", rd_data, m_rd);
        end
    end

    task automatic do_cmd(input logic [1:0] op, input logic [7:0] d);
        @(negedge clk); cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
        @(negedge clk); cmd_valid = 1'b0;
    endtask

    task automatic verify_exp(input logic [7:0] exp, input string tag);
        do_cmd(2'b01, 8'h00);
        @(negedge clk);
        check(rd_valid == 1'b1, tag, rd_valid, 1);
        check(rd_data == exp, tag, rd_data, exp);
    endtask

    task automatic prog_exp(input logic [7:0] d, input bit exp_err, input string tag);
        do_cmd(2'b00, d);
        @(negedge clk);
        check(error == exp_err, tag, error, exp_err);
        @(negedge clk);
        check(error == 1'b0, tag, error, 0);
    endtask

    task automatic step_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); step_pulse = 1'b1;
            @(negedge clk); step_pulse = 1'b0;
        end
    endtask

    task automatic ptr_clear();
        @(negedge clk); prog_rst = 1'b1;
        @(negedge clk); prog_rst = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(busy == 0 && error == 0 && rd_valid == 0, "R1 idle outputs", {busy, error, rd_valid}, 0);
        verify_exp(8'hFF, "R1 blank after reset");

        prog_exp(8'h5A, 0, "R4 blank write accepted");
        verify_exp(8'h5A, "R9 readback");
        prog_exp(8'h00, 1, "R5 rewrite refused");
        verify_exp(8'h5A, "R5 array unchanged");

        // R3 long pulse counts once
        step_n(3);
        @(negedge clk); step_pulse = 1'b1;
        repeat (4) @(negedge clk);
        step_pulse = 1'b0;
        verify_exp(8'hFF, "R3 addr4 blank");
        prog_exp(8'h33, 0, "R4 write at addr4");

        ptr_clear();
        verify_exp(8'h5A, "R2 pointer cleared");

        // R2 level held high does not pin pointer
        @(negedge clk); prog_rst = 1'b1;
        step_n(1);
        verify_exp(8'hFF, "R2 step while held");
        @(negedge clk); prog_rst = 1'b0;
        step_n(3);
        verify_exp(8'h33, "R3 addr4 data");

        // R11 command during busy ignored
        step_n(3);
        do_cmd(2'b00, 8'h11);
        cmd_valid = 1'b1; cmd_op = 2'b01;
        @(negedge clk); cmd_valid = 1'b0;
        check(error == 0, "R11 write ok", error, 0);
        @(negedge clk);
        check(rd_valid == 0, "R11 dropped read", rd_valid, 0);
        verify_exp(8'h11, "R4 addr7 data");

        // R3 full lap
        step_n(DEPTH);
        verify_exp(8'h11, "R3 wrap lap");

        // R6 write guard via bit0=0, R7 refusal
        do_cmd(2'b11, 8'h00);
        step_n(1);
        prog_exp(8'h22, 1, "R7 guarded write refused");
        verify_exp(8'hFF, "R7 array unchanged");

        // R6 read guard via bit0=1, R8
        do_cmd(2'b11, 8'h01);
        ptr_clear();
        verify_exp(8'hFF, "R8 guarded read");

        // R10 erase
        begin
            int cnt;
            do_cmd(2'b10, 8'h00);
            cnt = 0;
            while (busy && cnt < 100) begin cnt++; @(negedge clk); end
            check(cnt == ERASE_CYC, "R10 erase busy length", cnt, ERASE_CYC);
        end
        verify_exp(8'hFF, "R10 byte erased");
        prog_exp(8'h77, 0, "R10 guards cleared");
        verify_exp(8'h77, "R10 readable again");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule